// File: doc/BRIEF.md
# Programmable Baud Divisor Generator

This block turns a fast main clock into the sampling enables of a serial port. A 16-bit divisor, written one byte at a time through a small host register port, sets how many main-clock cycles lie between two pulses of the oversampling tick. That tick runs at sixteen times the line rate, so the line rate equals the main clock divided by sixteen times the divisor. A second output divides the oversampling tick by sixteen and marks each bit period of the line.

The two divisor bytes share their host addresses with the data and interrupt-enable registers of the surrounding port. A latch-access flag, kept in the line control register that this block also holds, decides whether a host access reaches the divisor. Any write to a divisor byte restarts both dividers at once, so the new rate applies from the next cycle without waiting out the old count.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the divisor and the line control register are zero, `tick16` and `tick1` stay low, and reads of every address return 0.
- R2: With the latch-access flag (line control bit 7) at 1, a write to address 0 sets the divisor low byte and a write to address 1 sets the high byte; reads of those addresses return the stored bytes.
- R3: With the latch-access flag at 0, writes to addresses 0 and 1 leave the divisor and the running tick rate unchanged, and reads of those addresses return 0.
- R4: The line control register sits at address 3, is written and read as a full byte, and its bit 7 is the latch-access flag.
- R5: For a divisor N of 2 or more, `tick16` is a one-cycle pulse that first rises N-1 cycles after the clock edge that wrote the last divisor byte, then repeats every N cycles.
- R6: A divisor of 0 holds `tick16` and `tick1` low.
- R7: A divisor of 1 holds `tick16` high on every cycle, starting with the cycle after the write.
- R8: `tick1` is high only together with `tick16`, on every sixteenth `tick16` pulse counted from the last divisor write, so its first pulse comes 16N-1 cycles after that write and its period is 16N cycles.
- R9: A divisor write while the counters run restarts them: the first `tick16` with the new divisor N comes N-1 cycles after the write, whatever the old phase was.
- R10: A divisor of 30 gives a `tick1` period of 480 cycles (38,400 baud from 18.432 MHz) and a divisor of 10,473 gives a `tick16` period of 10,473 cycles (about 110 baud from the same clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current address |
| tick16 | output | 1 | Oversampling enable, sixteen times the line rate |
| tick1 | output | 1 | Bit-rate enable, one per sixteen oversampling ticks |

## Verification
On every cycle the assertions check that a zero divisor keeps the oversampling tick silent, that a unit divisor keeps it high, that a tick with a larger divisor is never followed at once by another unless a write intervened, that the bit-rate tick only fires with an oversampling tick, and that divisor writes either land or are blocked according to the latch-access flag. The exact spacing of ticks for each divisor, the restart on a write in mid-count, the sixteen-to-one phase of the bit-rate tick and the readback through the shared addresses are shown only by the bench's scenarios, which count cycles between pulses.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    localparam int DIV_W    = 16;
    localparam int OVS      = 16;
    localparam int ADDR_W   = 3;
    localparam int BYTE_W   = 8;

    localparam logic [ADDR_W-1:0] ADDR_DIV_LO   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV_HI   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_LINE_CTL = 3'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } divisor_t;

    typedef struct packed {
        logic              latch_access;
        logic [BYTE_W-2:0] rest;
    } line_ctl_t;

    function automatic logic [DIV_W-1:0] div_value(divisor_t d);
        return {d.hi, d.lo};
    endfunction

endpackage

// File: rtl/uart_baud_regs.sv
module uart_baud_regs
    import uart_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output divisor_t          divisor,
    output divisor_t          load_val,
    output logic              load,
    output logic              dl
);

    line_ctl_t line_ctl;
    logic      sel_lo;
    logic      sel_hi;

    assign dl = line_ctl.latch_access;

    always_comb begin
        sel_lo   = wr && dl && (addr == ADDR_DIV_LO);
        sel_hi   = wr && dl && (addr == ADDR_DIV_HI);
        load     = sel_lo || sel_hi;
        load_val = divisor;
        if (sel_lo) load_val.lo = wdata;
        if (sel_hi) load_val.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor  <= '0;
            line_ctl <= '0;
        end else begin
            if (load) divisor <= load_val;
            if (wr && addr == ADDR_LINE_CTL) line_ctl <= line_ctl_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_DIV_LO:   if (dl) rdata = divisor.lo;
            ADDR_DIV_HI:   if (dl) rdata = divisor.hi;
            ADDR_LINE_CTL: rdata = line_ctl;
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_baud_counter.sv
module uart_baud_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_div,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_div;
        end else if (div == '0) begin
            cnt <= '0;
        end else if (cnt <= ONE) begin
            cnt <= div;
        end else begin
            cnt <= cnt - ONE;
        end
    end

    assign tick = (cnt == ONE);

endmodule

// File: rtl/uart_baud_subdiv.sv
module uart_baud_subdiv #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick_in,
    output logic tick_out
);

    generate
        if (OVS <= 1) begin : g_pass
            assign tick_out = tick_in;
        end else begin : g_div
            localparam int SUB_W = $clog2(OVS);
            localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

            logic [SUB_W-1:0] sub;

            always_ff @(posedge clk) begin
                if (rst || load) begin
                    sub <= '0;
                end else if (tick_in) begin
                    sub <= (sub == LAST) ? '0 : sub + SUB_W'(1);
                end
            end

            assign tick_out = tick_in && (sub == LAST);
        end
    endgenerate

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       tick16,
    output logic       tick1
);

    divisor_t          div_q;
    divisor_t          div_next;
    logic              load_q;
    logic              dl_q;
    logic [DIV_W-1:0]  divisor_q;

    assign divisor_q = div_value(div_q);

    uart_baud_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (host_addr),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .divisor  (div_q),
        .load_val (div_next),
        .load     (load_q),
        .dl       (dl_q)
    );

    uart_baud_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_q),
        .load_div (div_value(div_next)),
        .div      (divisor_q),
        .tick     (tick16)
    );

    uart_baud_subdiv #(.OVS(OVS)) u_sub (
        .clk      (clk),
        .rst      (rst),
        .load     (load_q),
        .tick_in  (tick16),
        .tick_out (tick1)
    );

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  host_addr,
    input logic        host_wr,
    input logic [7:0]  host_wdata,
    input logic        tick16,
    input logic        tick1,
    input logic [15:0] divisor,
    input logic        dl,
    input logic        load
);

    assert_zero_div_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (divisor == 16'd0) |-> (!tick16 && !tick1));

    assert_unit_div_always_R7: assert property (@(posedge clk) disable iff (rst)
        (divisor == 16'd1) |-> tick16);

    assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (rst)
        (tick16 && divisor > 16'd1 && !load) |=> !tick16);

    assert_bit_tick_inside_R8: assert property (@(posedge clk) disable iff (rst)
        tick1 |-> tick16);

    assert_locked_divisor_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !dl && host_addr <= 3'd1) |=> $stable(divisor));

    assert_low_byte_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && dl && host_addr == 3'd0) |=> (divisor[7:0] == $past(host_wdata)));

    assert_high_byte_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && dl && host_addr == 3'd1) |=> (divisor[15:8] == $past(host_wdata)));

endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .tick16     (tick16),
    .tick1      (tick1),
    .divisor    (divisor_q),
    .dl         (dl_q),
    .load       (load_q)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tick16;
    logic       tick1;

    int checks = 0;
    int failures = 0;
    int mism = 0;

    always #2 clk = ~clk;

    uart_baud_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tick16     (tick16),
        .tick1      (tick1)
    );

    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'd2, 16'd3, 16'd30, 16'd256, 16'd10473, 16'd7};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        host_addr = a; #1;
        v = host_rdata;
    endtask

    // which=0 watches tick16, which=1 watches tick1; k=0 is the cycle right after the last edge
    task automatic meas(input bit which, input int limit, output int f, output int s);
        f = -1; s = -1; mism = 0;
        for (int k = 0; k < limit; k++) begin
            if (tick1 && !tick16) mism++;
            if (which ? tick1 : tick16) begin
                if (f < 0) f = k;
                else begin s = k; break; end
            end
            @(posedge clk); #1;
        end
    endtask

    task automatic set_div(input logic [15:0] n);
        wr(3'd1, n[15:8]);
        wr(3'd0, n[7:0]);
    endtask

    initial begin
        #(150000 * 4);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int v, f, s;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 tick16", tick16, 0);
        check("R1 tick1", tick1, 0);
        rd(3'd0, v); check("R1 rdata addr0", v, 0);
        rd(3'd3, v); check("R1 rdata addr3", v, 0);
        meas(1'b0, 40, f, s); check("R1 no tick16", f, -1);

        // R4 line control
        wr(3'd3, 8'h83);
        rd(3'd3, v); check("R4 line ctl readback", v, 8'h83);
        wr(3'd3, 8'h80);

        // R2/R5/R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            set_div(VEC[i]);
            meas(1'b0, 3 * int'(VEC[i]) + 5, f, s);
            check("R5 first tick16", f, int'(VEC[i]) - 1);
            check("R5 period tick16", s - f, int'(VEC[i]));
            if (VEC[i] == 16'd10473) check("R10 110 baud tick16 period", s - f, 10473);
            rd(3'd0, v); check("R2 low byte", v, int'(VEC[i][7:0]));
            rd(3'd1, v); check("R2 high byte", v, int'(VEC[i][15:8]));
        end

        // R7 divisor 1
        set_div(16'd1);
        meas(1'b0, 10, f, s);
        check("R7 first", f, 0);
        check("R7 second", s, 1);

        // R6 divisor 0
        set_div(16'd0);
        meas(1'b0, 100, f, s); check("R6 tick16 silent", f, -1);
        check("R6 tick1 low", tick1, 0);

        // R8/R10 bit tick at divisor 30
        set_div(16'd30);
        meas(1'b1, 1200, f, s);
        check("R8 first tick1", f, 479);
        check("R10 38400 baud period", s - f, 480);
        check("R8 tick1 only with tick16", mism, 0);

        // R9 restart mid-count
        set_div(16'd100);
        repeat (50) @(posedge clk); #1;
        wr(3'd0, 8'd10);
        meas(1'b0, 40, f, s);
        check("R9 restart first", f, 9);
        check("R9 restart period", s - f, 10);

        // R3 locked when latch access clear
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h55);
        wr(3'd1, 8'h66);
        rd(3'd0, v); check("R3 read addr0 hidden", v, 0);
        rd(3'd1, v); check("R3 read addr1 hidden", v, 0);
        meas(1'b0, 40, f, s);
        check("R3 rate unchanged", s - f, 10);
        wr(3'd3, 8'h80);
        rd(3'd0, v); check("R3 low byte kept", v, 10);
        rd(3'd1, v); check("R3 high byte kept", v, 0);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        rd(3'd3, v); check("R1 line ctl cleared", v, 0);
        check("R1 tick16 after reset", tick16, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule